// File: doc/BRIEF.md
# Injector Pulse Width Meter with Stale-Value Timeout

This block watches a synchronous injector drive line together with a crank angle input. For each injection pulse it measures how long the line stays active, in clock ticks. It also captures the crank angle where injection begins and where it ends, and the forward angular span between those two angles. All four results are published together when the injector line falls, and a one-cycle valid strobe marks each publication.

A downstream model must not keep using old numbers once the injector stops firing, for example when injection is cut at high engine speed. For that reason the meter clears all four results to zero when no pulse completes within a configured window. The window is either a number of milliseconds, or one full angle cycle of crank travel counted since the last published pulse. A one-cycle clear strobe marks each timeout. A pulse that is still active when the window runs out is dropped. The next rising edge starts a fresh measurement.

Control is a two-state machine. In `ST_WAIT` the meter idles. The *start* transition to `ST_PULSE` is taken on a rising edge of the injector line. From `ST_PULSE` the meter returns to `ST_WAIT` by one of two transitions. The *publish* transition is taken on a falling edge. The *discard* transition is taken on a timeout while the pulse is still active.

Top module: `injm_pulse_meter`

## Requirements
- R1: After reset, `dur_ticks`, `soi_ang`, `eoi_ang` and `span_ang` are 0, and `meas_vld` and `to_clr` are low.
- R2: `dur_ticks` equals the number of rising clock edges at which `inj_in` was sampled high during the pulse. It is published in the cycle after the edge that samples `inj_in` low, and `meas_vld` is high for exactly that one cycle.
- R3: `soi_ang` is the `crank_ang` value sampled on the same edge that first sees `inj_in` high. `eoi_ang` is the `crank_ang` value sampled on the same edge that first sees it low.
- R4: `span_ang` equals (`eoi_ang` − `soi_ang`) modulo ANG_CYCLE. The result is in the range 0 to ANG_CYCLE−1, and a crossing of the cycle wrap is handled.
- R5: The duration count saturates at 2^TICK_W − 1 and does not wrap.
- R6: With `to_sel`=0 and `to_ms`>0, the clear fires on the rising edge that completes `to_ms`×TICKS_PER_MS cycles since the last publish edge or the last clear, provided no publish occurs in that time. On that edge all four results go to 0 and `to_clr` pulses for one cycle. Before that edge the results keep their published values.
- R7: With `to_sel`=0 and `to_ms`=0, the time-based clear is disabled and published values are held indefinitely.
- R8: With `to_sel`=1, the forward crank travel is accumulated modulo ANG_CYCLE from sample to sample, starting at the last publish edge. The clear of R6 fires on the edge where the accumulated travel reaches ANG_CYCLE.
- R9: A pulse that is active when a clear fires is discarded: its falling edge publishes nothing. A measurement starts again only at the next rising edge of `inj_in`.
- R10: `meas_vld` and `to_clr` are never high in the same cycle. When a falling edge and an expiry coincide, the publish wins.
- R11: The controller moves `ST_WAIT`→`ST_PULSE` on a rising edge. It moves `ST_PULSE`→`ST_WAIT` on a publish or on a discard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_in | input | 1 | Injector drive line, already synchronous to clk, active high |
| crank_ang | input | ANG_W | Crank angle, 0 to ANG_CYCLE−1 |
| to_sel | input | 1 | Timeout mode: 0 selects the millisecond window, 1 selects one angle cycle of travel |
| to_ms | input | MS_W | Millisecond window length; 0 disables the time window |
| dur_ticks | output | TICK_W | Pulse duration in clock ticks |
| soi_ang | output | ANG_W | Crank angle at start of injection |
| eoi_ang | output | ANG_W | Crank angle at end of injection |
| span_ang | output | ANG_W | Angular duration, modulo ANG_CYCLE |
| meas_vld | output | 1 | One-cycle strobe on each published measurement |
| to_clr | output | 1 | One-cycle strobe when a timeout clears the results |

## Verification
The embedded properties check, on every cycle, the invariants that do not depend on stimulus history:
- the two strobes are exclusive and each lasts one cycle;
- a clear always leaves zeroed results;
- the duration counter holds once it is saturated;
- a publish always returns the controller to `ST_WAIT`;
- both timeout counters restart after an expiry.

The exact duration and angle values, the wrap-around span, the cycle on which each kind of timeout fires, and the discard of an over-long pulse all depend on the stimulus sequence. Only the bench scenarios can show those.

// File: rtl/injm_pkg.sv
package injm_pkg;
    typedef enum logic [0:0] {
        ST_WAIT  = 1'b0,
        ST_PULSE = 1'b1
    } meas_st_t;
endpackage

// File: rtl/injm_angdiff.sv
// Forward angular distance from a_from to a_to on a cycle of ANG_CYCLE units.
module injm_angdiff #(
    parameter int ANG_W     = 10,
    parameter int ANG_CYCLE = 720
) (
    input  logic [ANG_W-1:0] a_from,
    input  logic [ANG_W-1:0] a_to,
    output logic [ANG_W-1:0] diff
);
    localparam logic [ANG_W-1:0] CYC_N = ANG_W'(ANG_CYCLE);

    // Arithmetic modulo 2^ANG_W gives the right value because the result is below ANG_CYCLE.
    always_comb begin
        if (a_to >= a_from) diff = a_to - a_from;
        else                diff = a_to - a_from + CYC_N;
    end
endmodule

// File: rtl/injm_edge.sv
module injm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic sig_q,
    output logic rise,
    output logic fall
);
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_in;
    end

    assign rise = sig_in & ~sig_q;
    assign fall = ~sig_in & sig_q;

    // R11
    rise_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> sig_q);
endmodule

// File: rtl/injm_timeout.sv
// Expiry source: a millisecond window or one full angle cycle of crank travel.
module injm_timeout #(
    parameter int ANG_W        = 10,
    parameter int ANG_CYCLE    = 720,
    parameter int TICKS_PER_MS = 250000,
    parameter int MS_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             sel_rev,
    input  logic [MS_W-1:0]  to_ms,
    input  logic [ANG_W-1:0] crank_ang,
    output logic             expire
);
    localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);
    localparam logic [ANG_W:0]   CYC      = (ANG_W+1)'(ANG_CYCLE);

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;
    logic             ms_tick, time_en, time_exp;

    logic [ANG_W-1:0] prev_q, delta;
    logic             primed_q;
    logic [ANG_W:0]   trav_q, trav_nxt;
    logic             rev_exp;

    // ---- time window ----
    assign ms_tick  = (pre_q == PRE_LAST);
    assign time_en  = !sel_rev && (to_ms != '0);
    assign time_exp = time_en && ms_tick &&
                      (({1'b0, ms_q} + {{MS_W{1'b0}}, 1'b1}) >= {1'b0, to_ms});

    always_ff @(posedge clk) begin
        if (!rst_n || restart || expire || !time_en) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (ms_tick) begin
            pre_q <= '0;
            if (ms_q != '1) ms_q <= ms_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // ---- crank travel window ----
    injm_angdiff #(.ANG_W(ANG_W), .ANG_CYCLE(ANG_CYCLE)) u_step (
        .a_from (prev_q),
        .a_to   (crank_ang),
        .diff   (delta)
    );

    assign trav_nxt = trav_q + {1'b0, delta};
    assign rev_exp  = sel_rev && primed_q && (trav_nxt >= CYC);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
            trav_q   <= '0;
        end else begin
            prev_q   <= crank_ang;
            primed_q <= 1'b1;
            if (restart || expire || !sel_rev) trav_q <= '0;
            else if (primed_q)                 trav_q <= trav_nxt;
        end
    end

    assign expire = time_exp | rev_exp;

    // R6 R8
    window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (ms_q == '0 && pre_q == '0 && trav_q == '0));
    // R7
    time_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_rev && to_ms == '0) |-> !expire);
endmodule

// File: rtl/injm_pulse_meter.sv
module injm_pulse_meter
    import injm_pkg::*;
#(
    parameter int TICK_W       = 24,
    parameter int ANG_W        = 10,
    parameter int ANG_CYCLE    = 720,
    parameter int TICKS_PER_MS = 250000,
    parameter int MS_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inj_in,
    input  logic [ANG_W-1:0]  crank_ang,
    input  logic              to_sel,
    input  logic [MS_W-1:0]   to_ms,
    output logic [TICK_W-1:0] dur_ticks,
    output logic [ANG_W-1:0]  soi_ang,
    output logic [ANG_W-1:0]  eoi_ang,
    output logic [ANG_W-1:0]  span_ang,
    output logic              meas_vld,
    output logic              to_clr
);
    meas_st_t          state_q, state_d;
    logic              inj_q, rise, fall;
    logic              expire, publish, kill;
    logic [TICK_W-1:0] cnt_q;
    logic [ANG_W-1:0]  soi_lat, span_now;

    injm_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (inj_in),
        .sig_q  (inj_q),
        .rise   (rise),
        .fall   (fall)
    );

    injm_timeout #(
        .ANG_W(ANG_W), .ANG_CYCLE(ANG_CYCLE),
        .TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)
    ) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (publish),
        .sel_rev   (to_sel),
        .to_ms     (to_ms),
        .crank_ang (crank_ang),
        .expire    (expire)
    );

    injm_angdiff #(.ANG_W(ANG_W), .ANG_CYCLE(ANG_CYCLE)) u_span (
        .a_from (soi_lat),
        .a_to   (crank_ang),
        .diff   (span_now)
    );

    assign publish = fall && (state_q == ST_PULSE);
    assign kill    = expire && !publish;

    // ---- state register ----
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // ---- next state ----
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (rise)                 state_d = ST_PULSE;  // start
            ST_PULSE: if (publish || kill)      state_d = ST_WAIT;   // publish / discard
            default:                            state_d = ST_WAIT;
        endcase
    end

    // ---- measurement datapath ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            soi_lat <= '0;
        end else if (state_q == ST_WAIT && rise) begin
            cnt_q   <= {{(TICK_W-1){1'b0}}, 1'b1};
            soi_lat <= crank_ang;
        end else if (state_q == ST_PULSE && inj_in && !kill && cnt_q != '1) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // ---- outputs ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dur_ticks <= '0;
            soi_ang   <= '0;
            eoi_ang   <= '0;
            span_ang  <= '0;
            meas_vld  <= 1'b0;
            to_clr    <= 1'b0;
        end else begin
            meas_vld <= 1'b0;
            to_clr   <= 1'b0;
            if (publish) begin
                dur_ticks <= cnt_q;
                soi_ang   <= soi_lat;
                eoi_ang   <= crank_ang;
                span_ang  <= span_now;
                meas_vld  <= 1'b1;
            end else if (kill) begin
                dur_ticks <= '0;
                soi_ang   <= '0;
                eoi_ang   <= '0;
                span_ang  <= '0;
                to_clr    <= 1'b1;
            end
        end
    end

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(meas_vld && to_clr));
    // R2
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld |=> !meas_vld);
    // R2
    vld_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld |-> !inj_q);
    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_clr |-> (dur_ticks == '0 && soi_ang == '0 && eoi_ang == '0 && span_ang == '0));
    // R5
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && inj_in && cnt_q == '1) |=> cnt_q == '1);
    // R11
    publish_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        publish |=> state_q == ST_WAIT);
endmodule

// File: tb/tb_injm_pulse_meter.sv
`timescale 1ns/1ps
module tb_injm_pulse_meter;
    localparam int TICK_W = 8;
    localparam int ANG_W  = 10;
    localparam int CYCLE  = 720;
    localparam int TPM    = 4;
    localparam int MS_W   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              inj_in = 1'b0;
    logic [ANG_W-1:0]  crank_ang = '0;
    logic              to_sel = 1'b0;
    logic [MS_W-1:0]   to_ms = '0;
    logic [TICK_W-1:0] dur_ticks;
    logic [ANG_W-1:0]  soi_ang, eoi_ang, span_ang;
    logic              meas_vld, to_clr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    injm_pulse_meter #(
        .TICK_W(TICK_W), .ANG_W(ANG_W), .ANG_CYCLE(CYCLE),
        .TICKS_PER_MS(TPM), .MS_W(MS_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .inj_in(inj_in), .crank_ang(crank_ang),
        .to_sel(to_sel), .to_ms(to_ms), .dur_ticks(dur_ticks),
        .soi_ang(soi_ang), .eoi_ang(eoi_ang), .span_ang(span_ang),
        .meas_vld(meas_vld), .to_clr(to_clr)
    );

    // soi, eoi, cycles high, expected duration, expected span
    localparam int VEC [4][5] = '{
        '{100, 250,  5,  5, 150},
        '{700,  20,  3,  3,  40},
        '{300, 300,  1,  1,   0},
        '{  0, 719, 10, 10, 719}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Leaves time just after the publish edge.
    task automatic run_pulse(input int soi, input int eoi, input int n);
        inj_in    = 1'b1;
        crank_ang = ANG_W'(soi);
        repeat (n) step();
        inj_in    = 1'b0;
        crank_ang = ANG_W'(eoi);
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit early, seen;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 dur", int'(dur_ticks), 0);
        check("R1 soi", int'(soi_ang), 0);
        check("R1 span", int'(span_ang), 0);
        check("R1 strobes", int'({meas_vld, to_clr}), 0);

        // R2 R3 R4 vector table, time window disabled
        for (int i = 0; i < 4; i++) begin
            run_pulse(VEC[i][0], VEC[i][1], VEC[i][2]);
            check("R2 vld", int'(meas_vld), 1);
            check("R2 dur", int'(dur_ticks), VEC[i][3]);
            check("R3 soi", int'(soi_ang), VEC[i][0]);
            check("R3 eoi", int'(eoi_ang), VEC[i][1]);
            check("R4 span", int'(span_ang), VEC[i][4]);
            step();
            check("R2 vld one cycle", int'(meas_vld), 0);
        end

        // R5 saturation
        run_pulse(10, 20, 300);
        check("R5 saturated dur", int'(dur_ticks), 255);

        // R6 time window of 3 ms = 12 cycles after publish edge
        to_ms = 8'd3;
        run_pulse(40, 60, 2);
        check("R6 publish", int'(dur_ticks), 2);
        early = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            step();
            if (k < 12 && (to_clr || dur_ticks != 8'd2)) early = 1'b1;
        end
        check("R6 held before expiry", int'(early), 0);
        check("R6 clr strobe", int'(to_clr), 1);
        check("R6 cleared dur", int'(dur_ticks), 0);
        check("R6 cleared eoi", int'(eoi_ang), 0);
        step();
        check("R6 clr one cycle", int'(to_clr), 0);

        // R9 long pulse discarded
        to_ms = 8'd2;
        inj_in = 1'b1;
        crank_ang = 10'd5;
        repeat (20) step();
        inj_in = 1'b0;
        crank_ang = 10'd50;
        step();
        check("R9 no publish", int'(meas_vld), 0);
        check("R9 dur zero", int'(dur_ticks), 0);
        to_ms = 8'd0;
        step();
        run_pulse(0, 30, 4);
        check("R9 fresh measurement", int'(dur_ticks), 4);

        // R7 disabled window holds values
        seen = 1'b0;
        for (int k = 0; k < 100; k++) begin
            step();
            if (to_clr) seen = 1'b1;
        end
        check("R7 no clear", int'(seen), 0);
        check("R7 value held", int'(dur_ticks), 4);

        // R8 one angle cycle of travel, 100 per sample -> fires at 8th sample
        to_sel = 1'b1;
        step();
        run_pulse(30, 80, 3);
        check("R8 publish", int'(span_ang), 50);
        early = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            crank_ang = ANG_W'((80 + 100 * k) % CYCLE);
            step();
            if (k < 8 && to_clr) early = 1'b1;
        end
        check("R8 no early clear", int'(early), 0);
        check("R8 clr strobe", int'(to_clr), 1);
        check("R8 cleared span", int'(span_ang), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule